// File: doc/BRIEF.md
# Serial Control Register Port

This block is the control-register front end of an audio converter. A host drives a 16-bit serial frame over four lines: a chip select, a serial clock, a data input and a data output. Each frame carries a two-bit device code, a direction bit, a five-bit register address and an eight-bit data byte. The block holds ten 8-bit registers with fixed reset values and presents their fields as parallel outputs to the rest of the chip.

The serial lines and the audio master clock are asynchronous to the system clock `clk`. The block synchronises them and detects their edges. A mode bit inside the register file turns the port into a write-only interface: in that mode read commands are dropped. Writes are also held off whenever the audio master clock has stopped. A stopped clock means that no master-clock edge has been seen for `MCLK_TIMEOUT` system clocks.

The data output is given as a value plus a drive enable. The pad ring turns the pair into a three-state pin.

Top module: `serial_regport`

## Requirements
- R1: A frame is sent MSB first and is captured on rising serial-clock edges in this order: device code bits [15:14], direction bit [13] (1 = write, 0 = read), address [12:8], data [7:0]. A write with device code 2'b01 updates the addressed register once the 16th rising edge after chip select falls has been seen.
- R2: After reset, register 00h holds 8Fh, 01h holds 5Bh, 02h holds 00h, 03h holds 81h, 04h holds 04h, and 05h to 09h hold 00h.
- R3: A frame whose device code is not 2'b01 writes nothing.
- R4: A frame in which chip select rises before the 16th rising edge writes nothing. This includes chip select rising in the same system-clock cycle in which the 16th edge is seen.
- R5: Writes to addresses 0Ah to 1Fh change no register. Reads of those addresses return 00h.
- R6: Register 09h stores only its two low bits. Its upper six bits always read 0.
- R7: On a read with device code 2'b01 and direction 0, `sdo_oe` rises and bit 7 of the addressed register appears on `sdo_data` at the falling edge that follows the 8th rising edge. The next seven falling edges present bits 6 to 0. `sdo_oe` is 0 at every other time and drops once chip select is high.
- R8: While register 02h bit 2 (write-only mode) is 1, read frames leave `sdo_oe` low. Writes still work in that mode.
- R9: When no master-clock edge has been seen for `MCLK_TIMEOUT` system clocks, write frames are discarded. Writes take effect again once master-clock edges return.
- R10: The field outputs map to the registers as follows. `fmt` = 00h[3:2], `pwr` = 00h[1], `run` = 00h[0]. `speed` = 01h[4:3], `deemph` = 01h[2:1], `gain` = 01h[0]. `inv_l` = 02h[4], `inv_r` = 02h[3], `three_wire` = 02h[2], `src_sel` = 02h[1:0]. `tx_valid` = 03h[1], `tx_en` = 03h[0]. `cs_bits` = {09h[1:0], 08h, 07h, 06h, 05h, 04h}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mclk | input | 1 | Audio master clock, watched for activity |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo_data | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Serial data out drive enable |
| fmt | output | 2 | Audio data format field |
| pwr | output | 1 | Power enable field |
| run | output | 1 | Timing run field |
| speed | output | 2 | Sampling speed field |
| deemph | output | 2 | De-emphasis field |
| gain | output | 1 | Output scale field |
| inv_l | output | 1 | Left polarity invert field |
| inv_r | output | 1 | Right polarity invert field |
| three_wire | output | 1 | Write-only port mode field |
| src_sel | output | 2 | Input source select field |
| tx_valid | output | 1 | Transmit validity field |
| tx_en | output | 1 | Transmit enable field |
| cs_bits | output | 42 | Transmit channel status bits |

## Verification
Frame abort and write commit can land in the same system-clock cycle. This happens when chip select rises together with the 16th rising serial-clock edge: both pass through synchroniser chains of equal length, so both are seen in one cycle. The bench drives both lines on the same clock edge for the last bit of a write frame. It then reads the register back and expects the old value, because the abort wins. A write frame sent just after the master clock has stopped is judged the same way: it must leave the register unchanged.

// File: rtl/serial_regport.sv
module serial_regport #(
  parameter int MCLK_TIMEOUT = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mclk,
  input  logic        cs_n,
  input  logic        sclk,
  input  logic        sdi,
  output logic        sdo_data,
  output logic        sdo_oe,
  output logic [1:0]  fmt,
  output logic        pwr,
  output logic        run,
  output logic [1:0]  speed,
  output logic [1:0]  deemph,
  output logic        gain,
  output logic        inv_l,
  output logic        inv_r,
  output logic        three_wire,
  output logic [1:0]  src_sel,
  output logic        tx_valid,
  output logic        tx_en,
  output logic [41:0] cs_bits
);

  localparam int NREGS = 10;
  localparam int FBITS = 16;
  localparam int HBITS = 8;
  localparam int CW    = $clog2(MCLK_TIMEOUT + 1);
  localparam int BW    = $clog2(FBITS + 1);

  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      0:       return 8'h8F;
      1:       return 8'h5B;
      3:       return 8'h81;
      4:       return 8'h04;
      default: return 8'h00;
    endcase
  endfunction

  logic [7:0] regs [NREGS];

  // input synchronisers
  logic [2:0] sclk_q, mclk_q;
  logic [1:0] cs_q, sdi_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= 3'b111;
      mclk_q <= 3'b000;
      cs_q   <= 2'b11;
      sdi_q  <= 2'b00;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      mclk_q <= {mclk_q[1:0], mclk};
      cs_q   <= {cs_q[0], cs_n};
      sdi_q  <= {sdi_q[0], sdi};
    end

  logic cs_s, sdi_s, sclk_rise, sclk_fall, mclk_edge;
  assign cs_s      = cs_q[1];
  assign sdi_s     = sdi_q[1];
  assign sclk_rise = sclk_q[1] & ~sclk_q[2];
  assign sclk_fall = ~sclk_q[1] & sclk_q[2];
  assign mclk_edge = mclk_q[1] ^ mclk_q[2];

  // master clock activity
  logic [CW-1:0] idle_cnt;
  logic          mclk_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      idle_cnt <= CW'(MCLK_TIMEOUT);
    else if (mclk_edge)
      idle_cnt <= '0;
    else if (idle_cnt != CW'(MCLK_TIMEOUT))
      idle_cnt <= idle_cnt + 1'b1;

  assign mclk_ok = (idle_cnt != CW'(MCLK_TIMEOUT));

  // frame engine
  logic [FBITS-1:0] shreg, nxt_frame;
  logic [BW-1:0]    bit_cnt;
  logic [7:0]       out_sr;
  logic             wr_stb;
  logic [4:0]       wr_addr;
  logic [7:0]       wr_data;
  logic [4:0]       rd_addr;
  logic [7:0]       rd_data;
  logic             rd_ok, wr_ok;

  assign nxt_frame = {shreg[FBITS-2:0], sdi_s};
  assign wr_ok     = (nxt_frame[15:14] == 2'b01) && nxt_frame[13] &&
                     (int'(nxt_frame[12:8]) < NREGS) && mclk_ok;
  assign rd_addr   = shreg[4:0];
  assign rd_data   = (int'(rd_addr) < NREGS) ? regs[rd_addr[3:0]] : 8'h00;
  assign rd_ok     = (shreg[7:6] == 2'b01) && !shreg[5] && !three_wire;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
      out_sr  <= '0;
      sdo_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (cs_s) begin
        bit_cnt <= '0;
        sdo_oe  <= 1'b0;
      end else begin
        if (sclk_rise && bit_cnt != BW'(FBITS)) begin
          shreg   <= nxt_frame;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == BW'(FBITS - 1)) begin
            wr_stb  <= wr_ok;
            wr_addr <= nxt_frame[12:8];
            wr_data <= nxt_frame[7:0];
          end
        end
        if (sclk_fall) begin
          if (bit_cnt == BW'(HBITS) && rd_ok) begin
            out_sr <= rd_data;
            sdo_oe <= 1'b1;
          end else if (bit_cnt > BW'(HBITS) && bit_cnt < BW'(FBITS)) begin
            out_sr <= {out_sr[6:0], 1'b0};
          end
        end
      end
    end

  assign sdo_data = out_sr[7];

  // register file
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= reg_default(i);
    end else if (wr_stb) begin
      if (wr_addr == 5'd9) regs[wr_addr[3:0]] <= {6'b0, wr_data[1:0]};
      else                 regs[wr_addr[3:0]] <= wr_data;
    end

  assign fmt        = regs[0][3:2];
  assign pwr        = regs[0][1];
  assign run        = regs[0][0];
  assign speed      = regs[1][4:3];
  assign deemph     = regs[1][2:1];
  assign gain       = regs[1][0];
  assign inv_l      = regs[2][4];
  assign inv_r      = regs[2][3];
  assign three_wire = regs[2][2];
  assign src_sel    = regs[2][1:0];
  assign tx_valid   = regs[3][1];
  assign tx_en      = regs[3][0];
  assign cs_bits    = {regs[9][1:0], regs[8], regs[7], regs[6], regs[5], regs[4]};

  // R1
  commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(sclk_rise) && $past(bit_cnt) == BW'(FBITS - 1));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= BW'(FBITS));

  // R7
  sdo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !sdo_oe);

  // R7
  sdo_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> bit_cnt >= BW'(HBITS));

  // R8
  rd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !$past(three_wire));

  // R9
  mclk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mclk_ok |=> !wr_stb);

  // R6
  top_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) && rd_addr == 5'd9 |-> out_sr[7:2] == 6'b0);

endmodule

// File: tb/serial_regport_test.sv
module serial_regport_test;

  logic clk = 0, rst_n = 0, mclk = 0, cs_n = 1, sclk = 1, sdi = 0;
  logic sdo_data, sdo_oe, pwr, run, gain, inv_l, inv_r, three_wire, tx_valid, tx_en;
  logic [1:0] fmt, speed, deemph, src_sel;
  logic [41:0] cs_bits;
  int checks = 0, failures = 0;
  bit mclk_run = 0;

  always #2.5 clk = ~clk;

  serial_regport uut (
    .clk(clk), .rst_n(rst_n), .mclk(mclk), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo_data(sdo_data), .sdo_oe(sdo_oe), .fmt(fmt), .pwr(pwr), .run(run),
    .speed(speed), .deemph(deemph), .gain(gain), .inv_l(inv_l), .inv_r(inv_r),
    .three_wire(three_wire), .src_sel(src_sel), .tx_valid(tx_valid), .tx_en(tx_en),
    .cs_bits(cs_bits));

  initial forever begin
    repeat (3) @(negedge clk);
    if (mclk_run) mclk = ~mclk;
  end

  // {addr[4:0], write data, expected read-back}
  localparam logic [20:0] VEC [8] = '{
    {5'h00, 8'hA6, 8'hA6}, {5'h01, 8'h3C, 8'h3C}, {5'h02, 8'h13, 8'h13},
    {5'h03, 8'h02, 8'h02}, {5'h04, 8'hFF, 8'hFF}, {5'h07, 8'h5A, 8'h5A},
    {5'h09, 8'hFF, 8'h03}, {5'h0C, 8'h77, 8'h00}};

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] w, input int nbits, input bit simul_end,
                      output logic [7:0] rd, output bit oe_seen);
    rd = 0;
    oe_seen = 0;
    @(negedge clk);
    cs_n = 0;
    wait_clk(6);
    for (int i = 0; i < nbits; i++) begin
      sdi = w[15-i];
      sclk = 0;
      wait_clk(6);
      if (i >= 8) begin
        rd = {rd[6:0], sdo_data};
        if (sdo_oe) oe_seen = 1;
      end
      sclk = 1;
      if (simul_end && i == nbits - 1) cs_n = 1;
      wait_clk(6);
    end
    cs_n = 1;
    wait_clk(8);
  endtask

  task automatic wr(input logic [1:0] chip, input logic [4:0] a, input logic [7:0] d);
    logic [7:0] r;
    bit o;
    xfer({chip, 1'b1, a, d}, 16, 0, r, o);
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v, output bit o);
    xfer({2'b01, 1'b0, a, 8'h00}, 16, 0, v, o);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    bit o;
    wait_clk(4);
    rst_n = 1;
    wait_clk(4);
    // R2 and R10: reset values at the field outputs
    check("R2 fmt/pwr/run", {fmt, pwr, run}, 4'b1111);
    check("R2 speed/deemph/gain", {speed, deemph, gain}, 5'b11011);
    check("R2 ctl3", {inv_l, inv_r, three_wire, src_sel}, 5'b0);
    check("R2 tx", {tx_valid, tx_en}, 2'b01);
    check("R2 cs_bits", cs_bits, 42'h4);
    rd(5'h00, v, o);
    check("R2 R7 read 00h", {o, v}, {1'b1, 8'h8F});
    rd(5'h03, v, o);
    check("R2 read 03h", v, 8'h81);
    check("R7 oe released", sdo_oe, 1'b0);

    mclk_run = 1;
    wait_clk(20);
    // R1 R5 R6 table of writes and read-backs
    foreach (VEC[k]) begin
      wr(2'b01, VEC[k][20:16], VEC[k][15:8]);
      rd(VEC[k][20:16], v, o);
      check("R1 R5 R6 read-back", v, VEC[k][7:0]);
    end
    // R10 field mapping after the table
    check("R10 ctl1", {fmt, pwr, run}, 4'b0110);
    check("R10 ctl2", {speed, deemph, gain}, 5'b11100);
    check("R10 ctl3", {inv_l, inv_r, three_wire, src_sel}, 5'b10011);
    check("R10 tx", {tx_valid, tx_en}, 2'b10);
    check("R5 R10 cs_bits", cs_bits, {2'b11, 8'h00, 8'h5A, 8'h00, 8'h00, 8'hFF});

    // R3 wrong device code
    wr(2'b10, 5'h01, 8'h00);
    rd(5'h01, v, o);
    check("R3 bad code", v, 8'h3C);
    wr(2'b00, 5'h04, 8'h00);
    check("R3 bad code cs_bits", cs_bits[7:0], 8'hFF);

    // R4 early chip select
    xfer({2'b01, 1'b1, 5'h01, 8'h00}, 12, 0, v, o);
    rd(5'h01, v, o);
    check("R4 short frame", v, 8'h3C);
    // R4 chip select rising with the 16th edge
    xfer({2'b01, 1'b1, 5'h01, 8'h00}, 16, 1, v, o);
    rd(5'h01, v, o);
    check("R4 simultaneous abort", v, 8'h3C);

    // R8 write-only mode
    wr(2'b01, 5'h02, 8'h04);
    check("R8 mode set", three_wire, 1'b1);
    rd(5'h00, v, o);
    check("R8 read suppressed", o, 1'b0);
    wr(2'b01, 5'h02, 8'h13);
    check("R8 write in 3-wire", {three_wire, src_sel}, 3'b011);
    rd(5'h02, v, o);
    check("R8 R7 read restored", {o, v}, {1'b1, 8'h13});

    // R9 master clock stopped
    mclk_run = 0;
    wait_clk(80);
    wr(2'b01, 5'h01, 8'h00);
    check("R9 write blocked", {speed, deemph, gain}, 5'b11100);
    rd(5'h01, v, o);
    check("R9 read still works", v, 8'h3C);
    mclk_run = 1;
    wait_clk(20);
    wr(2'b01, 5'h01, 8'h00);
    check("R9 write resumes", {speed, deemph, gain}, 5'b00000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule